// File: doc/BRIEF.md
# Two-Stage Scaler Ratio Calculator

This block turns a picture geometry into the control words of a two-stage image scaler: a coarse prescaler that divides by a power of two, and a fine main scaler that applies a fractional step. It takes a source frame size, a symmetric crop margin per axis and a target size. From these it derives the following values for each axis:

- the cropped (effective) source size,
- the prescale ratio and its log2 shift,
- a combined shift factor,
- the size of the prescaler output,
- an 8.8 fixed-point main-scaler step,
- a scale-up flag.

It also raises error flags for impossible geometries. The block only computes control words. The pixel path lives elsewhere.

A one-cycle `start` in the idle state captures all inputs and starts a run. The state machine has five states. `ST_IDLE` waits for start. `ST_SETUP` computes the cropped sizes and the prescale selection. `ST_DIV_H` and `ST_DIV_V` each run one pass of a shared bit-serial restoring divider for the main steps. `ST_FINISH` loads the result registers.

The transitions are:

- IDLE→SETUP on start.
- SETUP→FINISH on a size error; otherwise SETUP→DIV_H.
- DIV_H→DIV_V when the divider finishes.
- DIV_V→FINISH when the divider finishes.
- FINISH→IDLE always.

`done` pulses in the first idle cycle after FINISH, together with the new results. The results then hold until the next run completes.

Top module: `scaler_calc`

## Requirements
- R1: A `start` seen in idle begins a run. `busy` is high from the next cycle until the run ends. `done` is a one-cycle pulse with `busy` low. A `start` while busy is ignored, and so are input changes after the capturing cycle.
- R2: Effective width = `src_w` − 2·`ofs_h`; effective height = `src_h` − 2·`ofs_v`. If either is ≤ 0, or either target is 0, `err_size` is 1 and every other result output is 0.
- R3: Per axis, the shift is the largest k in 0..5 with effective ≥ target·2^k (0 if none). The ratio output is 2^shift: one-hot, with bit k meaning ratio 2^k.
- R4: `err_range` is 1 when effective ≥ 64·target on either axis. That axis then uses shift 5 (ratio 32).
- R5: `shift_factor` = 10 − (`pre_shift_h` + `pre_shift_v`).
- R6: `pre_dst_w`/`pre_dst_h` = effective size divided by that axis's prescale ratio, rounded down.
- R7: Main step per axis = floor((effective·256) / (target·2^shift)), with 8 fraction bits.
- R8: `scale_up_h`/`scale_up_v` are 1 when effective ≤ target. `err_mismatch` is 1 when the two differ.
- R9: With `preview` = 1, `err_linebuf` is 1 when `pre_dst_w` > 640. With `preview` = 0 it stays 0.
- R10: After reset all results, `done` and `busy` are 0. Results change only in a `done` cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a run (honoured only when idle) |
| preview | input | 1 | Enables the line-buffer width check |
| src_w | input | 12 | Source width |
| src_h | input | 12 | Source height |
| ofs_h | input | 11 | Horizontal crop margin per side |
| ofs_v | input | 11 | Vertical crop margin per side |
| tgt_w | input | 12 | Target width |
| tgt_h | input | 12 | Target height |
| busy | output | 1 | Run in progress |
| done | output | 1 | One-cycle completion pulse |
| pre_ratio_h | output | 6 | Horizontal prescale ratio (one-hot power of two) |
| pre_ratio_v | output | 6 | Vertical prescale ratio |
| pre_shift_h | output | 3 | log2 of horizontal ratio |
| pre_shift_v | output | 3 | log2 of vertical ratio |
| shift_factor | output | 4 | 10 minus the sum of the shifts |
| pre_dst_w | output | 12 | Prescaler output width |
| pre_dst_h | output | 12 | Prescaler output height |
| main_ratio_h | output | 20 | Horizontal main step, 8.8 fixed point |
| main_ratio_v | output | 20 | Vertical main step, 8.8 fixed point |
| scale_up_h | output | 1 | Horizontal enlargement |
| scale_up_v | output | 1 | Vertical enlargement |
| err_size | output | 1 | Non-positive cropped size or zero target |
| err_range | output | 1 | Reduction of 64 or more on an axis |
| err_mismatch | output | 1 | Axes disagree on enlargement |
| err_linebuf | output | 1 | Preview prescaled width above 640 |

## Verification
The bench drives exact threshold geometries:

- effective = 32·target and = 64·target, which a design with a strict compare or an off-by-one step count would place in the wrong ratio or flag wrongly;
- effective = target, which catches an inverted or strict scale-up compare.

Crop margins that leave zero or negative width must yield `err_size` with all-zero results; a design that skips the signed check would instead divide a wrapped size. A second start with different inputs arrives mid-run; a design that restarts or re-samples would report the second geometry. Prescaled preview widths of 640 and 641, and the same geometry with `preview` low, catch an off-by-one or unconditional line-buffer check.

// File: rtl/scaler_calc_pkg.sv
package scaler_calc_pkg;

    // number of prescale steps: ratios 1,2,4,8,16,32
    localparam int PRE_STEPS = 6;
    // fraction bits of the main-scaler step
    localparam int FRAC_BITS = 8;
    // constant the two shifts are subtracted from
    localparam int SF_BASE   = 10;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SETUP,
        ST_DIV_H,
        ST_DIV_V,
        ST_FINISH
    } calc_state_t;

endpackage

// File: rtl/scaler_ratio_sel.sv
module scaler_ratio_sel #(
    parameter int DIM_W = 12,
    parameter int STEPS = 6,
    localparam int SH_W  = $clog2(STEPS),
    localparam int CMP_W = DIM_W + STEPS + 1
) (
    input  logic [DIM_W-1:0] eff,
    input  logic [DIM_W-1:0] tgt,
    output logic [SH_W-1:0]  shift,
    output logic             over,
    output logic             up
);

    logic [STEPS:0] ge;

    for (genvar k = 0; k <= STEPS; k++) begin : g_cmp
        assign ge[k] = CMP_W'(eff) >= (CMP_W'(tgt) << k);
    end

    // highest satisfied threshold wins
    always_comb begin
        shift = '0;
        for (int k = 0; k < STEPS; k++) begin
            if (ge[k]) shift = SH_W'(k);
        end
    end

    assign over = ge[STEPS];
    assign up   = (eff <= tgt);

endmodule

// File: rtl/scaler_seq_div.sv
module scaler_seq_div #(
    parameter int N = 20,
    parameter int M = 17,
    localparam int CNT_W = $clog2(N)
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         go,
    input  logic [N-1:0] dividend,
    input  logic [M-1:0] divisor,
    output logic         done,
    output logic [N-1:0] quotient
);

    logic [M-1:0]     rem_q;
    logic [N-1:0]     quo_q;
    logic [M-1:0]     dvs_q;
    logic [CNT_W-1:0] cnt_q;
    logic             run_q;
    logic             done_q;
    logic [M:0]       trial;
    logic             fits;

    assign trial = {rem_q, quo_q[N-1]};
    assign fits  = (trial >= {1'b0, dvs_q});

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rem_q  <= '0;
            quo_q  <= '0;
            dvs_q  <= '0;
            cnt_q  <= '0;
            run_q  <= 1'b0;
            done_q <= 1'b0;
        end else begin
            done_q <= 1'b0;
            if (go && !run_q) begin
                rem_q <= '0;
                quo_q <= dividend;
                dvs_q <= divisor;
                cnt_q <= CNT_W'(N - 1);
                run_q <= 1'b1;
            end else if (run_q) begin
                rem_q <= fits ? M'(trial - {1'b0, dvs_q}) : trial[M-1:0];
                quo_q <= {quo_q[N-2:0], fits};
                if (cnt_q == '0) begin
                    run_q  <= 1'b0;
                    done_q <= 1'b1;
                end else begin
                    cnt_q <= cnt_q - 1'b1;
                end
            end
        end
    end

    assign done     = done_q;
    assign quotient = quo_q;

    // partial remainder always below the divisor while iterating (R7)
    assert_rem_bound_R7: assert property (@(posedge clk) disable iff (!rst_n)
        run_q |-> (rem_q < dvs_q));

    // never launched with a zero divisor or while already running (R7)
    assert_clean_launch_R7: assert property (@(posedge clk) disable iff (!rst_n)
        go |-> (divisor != '0) && !run_q);

endmodule

// File: rtl/scaler_calc.sv
module scaler_calc
    import scaler_calc_pkg::*;
#(
    parameter int DIM_W       = 12,
    parameter int LINEBUF_MAX = 640,
    localparam int OFS_W = DIM_W - 1,
    localparam int EFF_W = DIM_W + 1,
    localparam int SH_W  = $clog2(PRE_STEPS),
    localparam int DVD_W = DIM_W + FRAC_BITS,
    localparam int DVS_W = DIM_W + PRE_STEPS - 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             preview,
    input  logic [DIM_W-1:0] src_w,
    input  logic [DIM_W-1:0] src_h,
    input  logic [OFS_W-1:0] ofs_h,
    input  logic [OFS_W-1:0] ofs_v,
    input  logic [DIM_W-1:0] tgt_w,
    input  logic [DIM_W-1:0] tgt_h,
    output logic             busy,
    output logic             done,
    output logic [PRE_STEPS-1:0] pre_ratio_h,
    output logic [PRE_STEPS-1:0] pre_ratio_v,
    output logic [SH_W-1:0]  pre_shift_h,
    output logic [SH_W-1:0]  pre_shift_v,
    output logic [3:0]       shift_factor,
    output logic [DIM_W-1:0] pre_dst_w,
    output logic [DIM_W-1:0] pre_dst_h,
    output logic [DVD_W-1:0] main_ratio_h,
    output logic [DVD_W-1:0] main_ratio_v,
    output logic             scale_up_h,
    output logic             scale_up_v,
    output logic             err_size,
    output logic             err_range,
    output logic             err_mismatch,
    output logic             err_linebuf
);

    calc_state_t state_q, state_d;

    // captured request
    logic             l_preview;
    logic [DIM_W-1:0] l_src_w, l_src_h, l_tgt_w, l_tgt_h;
    logic [OFS_W-1:0] l_ofs_h, l_ofs_v;

    // working values
    logic             w_bad;
    logic [DIM_W-1:0] w_eff_w, w_eff_h;
    logic [SH_W-1:0]  w_sh_h, w_sh_v;
    logic             w_over_h, w_over_v, w_up_h, w_up_v;
    logic [DVD_W-1:0] w_main_h, w_main_v;

    // setup combinational path
    logic signed [EFF_W-1:0] eff_w_s, eff_h_s;
    logic [DIM_W-1:0] eff_w_c, eff_h_c;
    logic             bad_c;
    logic [SH_W-1:0]  sh_w_c, sh_h_c;
    logic             over_w_c, over_h_c, up_w_c, up_h_c;

    // divider hookup
    logic             div_go, div_done;
    logic [DVD_W-1:0] div_dvd, div_q;
    logic [DVS_W-1:0] div_dvs;

    assign eff_w_s = $signed({1'b0, l_src_w}) - $signed({1'b0, l_ofs_h, 1'b0});
    assign eff_h_s = $signed({1'b0, l_src_h}) - $signed({1'b0, l_ofs_v, 1'b0});
    assign eff_w_c = eff_w_s[DIM_W-1:0];
    assign eff_h_c = eff_h_s[DIM_W-1:0];
    assign bad_c   = (eff_w_s <= 0) || (eff_h_s <= 0) ||
                     (l_tgt_w == '0) || (l_tgt_h == '0);

    scaler_ratio_sel #(.DIM_W(DIM_W), .STEPS(PRE_STEPS)) u_sel_h (
        .eff(eff_w_c), .tgt(l_tgt_w), .shift(sh_w_c), .over(over_w_c), .up(up_w_c));

    scaler_ratio_sel #(.DIM_W(DIM_W), .STEPS(PRE_STEPS)) u_sel_v (
        .eff(eff_h_c), .tgt(l_tgt_h), .shift(sh_h_c), .over(over_h_c), .up(up_h_c));

    assign div_go  = ((state_q == ST_SETUP) && !bad_c) ||
                     ((state_q == ST_DIV_H) && div_done);
    assign div_dvd = (state_q == ST_SETUP) ? {eff_w_c, {FRAC_BITS{1'b0}}}
                                           : {w_eff_h, {FRAC_BITS{1'b0}}};
    assign div_dvs = (state_q == ST_SETUP) ? (DVS_W'(l_tgt_w) << sh_w_c)
                                           : (DVS_W'(l_tgt_h) << w_sh_v);

    scaler_seq_div #(.N(DVD_W), .M(DVS_W)) u_div (
        .clk(clk), .rst_n(rst_n), .go(div_go), .dividend(div_dvd),
        .divisor(div_dvs), .done(div_done), .quotient(div_q));

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (start) state_d = ST_SETUP;
            ST_SETUP:  state_d = bad_c ? ST_FINISH : ST_DIV_H;
            ST_DIV_H:  if (div_done) state_d = ST_DIV_V;
            ST_DIV_V:  if (div_done) state_d = ST_FINISH;
            ST_FINISH: state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    assign busy = (state_q != ST_IDLE);

    // capture, working and result registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            {l_preview, l_src_w, l_src_h, l_tgt_w, l_tgt_h, l_ofs_h, l_ofs_v} <= '0;
            {w_bad, w_eff_w, w_eff_h, w_sh_h, w_sh_v} <= '0;
            {w_over_h, w_over_v, w_up_h, w_up_v, w_main_h, w_main_v} <= '0;
            done <= 1'b0;
            {pre_ratio_h, pre_ratio_v, pre_shift_h, pre_shift_v, shift_factor} <= '0;
            {pre_dst_w, pre_dst_h, main_ratio_h, main_ratio_v} <= '0;
            {scale_up_h, scale_up_v, err_size, err_range, err_mismatch, err_linebuf} <= '0;
        end else begin
            done <= 1'b0;
            unique case (state_q)
                ST_IDLE: begin
                    if (start) begin
                        l_preview <= preview;
                        l_src_w <= src_w;  l_src_h <= src_h;
                        l_ofs_h <= ofs_h;  l_ofs_v <= ofs_v;
                        l_tgt_w <= tgt_w;  l_tgt_h <= tgt_h;
                    end
                end
                ST_SETUP: begin
                    w_bad    <= bad_c;
                    w_eff_w  <= eff_w_c;  w_eff_h  <= eff_h_c;
                    w_sh_h   <= sh_w_c;   w_sh_v   <= sh_h_c;
                    w_over_h <= over_w_c; w_over_v <= over_h_c;
                    w_up_h   <= up_w_c;   w_up_v   <= up_h_c;
                end
                ST_DIV_H: if (div_done) w_main_h <= div_q;
                ST_DIV_V: if (div_done) w_main_v <= div_q;
                ST_FINISH: begin
                    done <= 1'b1;
                    if (w_bad) begin
                        {pre_ratio_h, pre_ratio_v, pre_shift_h, pre_shift_v, shift_factor} <= '0;
                        {pre_dst_w, pre_dst_h, main_ratio_h, main_ratio_v} <= '0;
                        {scale_up_h, scale_up_v, err_range, err_mismatch, err_linebuf} <= '0;
                        err_size <= 1'b1;
                    end else begin
                        pre_shift_h  <= w_sh_h;
                        pre_shift_v  <= w_sh_v;
                        pre_ratio_h  <= PRE_STEPS'(1) << w_sh_h;
                        pre_ratio_v  <= PRE_STEPS'(1) << w_sh_v;
                        shift_factor <= 4'(SF_BASE) - 4'(w_sh_h) - 4'(w_sh_v);
                        pre_dst_w    <= w_eff_w >> w_sh_h;
                        pre_dst_h    <= w_eff_h >> w_sh_v;
                        main_ratio_h <= w_main_h;
                        main_ratio_v <= w_main_v;
                        scale_up_h   <= w_up_h;
                        scale_up_v   <= w_up_v;
                        err_size     <= 1'b0;
                        err_range    <= w_over_h | w_over_v;
                        err_mismatch <= w_up_h ^ w_up_v;
                        err_linebuf  <= l_preview &&
                                        ((w_eff_w >> w_sh_h) > DIM_W'(LINEBUF_MAX));
                    end
                end
                default: ;
            endcase
        end
    end

    // done is a single-cycle pulse outside busy (R1)
    assert_done_pulse_R1: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    assert_done_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);

    // results hold between completions (R10)
    assert_hold_results_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !done |-> $stable(main_ratio_h) && $stable(main_ratio_v) &&
                  $stable(pre_dst_w) && $stable(pre_dst_h) &&
                  $stable(pre_ratio_h) && $stable(err_size));

    // ratio is a single power of two (R3)
    assert_ratio_onehot_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !err_size) |-> ($countones(pre_ratio_h) == 1) &&
                                ($countones(pre_ratio_v) == 1));

    // shifts and shift factor sum to the base (R5)
    assert_shift_sum_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !err_size) |->
            (5'(shift_factor) + 5'(pre_shift_h) + 5'(pre_shift_v) == 5'(SF_BASE)));

    // size error clears the numeric results (R2)
    assert_size_clears_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (done && err_size) |-> (pre_ratio_h == '0) && (main_ratio_h == '0) &&
                               (main_ratio_v == '0) && !err_range);

    // range error forces the largest ratio on some axis (R4)
    assert_range_max_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (done && err_range) |-> (pre_shift_h == SH_W'(PRE_STEPS - 1)) ||
                                (pre_shift_v == SH_W'(PRE_STEPS - 1)));

endmodule

// File: tb/test_scaler_calc.sv
module test_scaler_calc;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic        preview = 1'b0;
    logic [11:0] src_w = '0, src_h = '0, tgt_w = '0, tgt_h = '0;
    logic [10:0] ofs_h = '0, ofs_v = '0;
    logic        busy, done;
    logic [5:0]  pre_ratio_h, pre_ratio_v;
    logic [2:0]  pre_shift_h, pre_shift_v;
    logic [3:0]  shift_factor;
    logic [11:0] pre_dst_w, pre_dst_h;
    logic [19:0] main_ratio_h, main_ratio_v;
    logic        scale_up_h, scale_up_v, err_size, err_range, err_mismatch, err_linebuf;

    int checks = 0;
    int fails  = 0;
    bit mon_on = 0;
    bit pend   = 0;

    // expected (currently shown) and pending (next done) result sets
    int e[17];
    int p[17];

    always #10 clk = ~clk;

    scaler_calc i_scaler_calc (
        .clk(clk), .rst_n(rst_n), .start(start), .preview(preview),
        .src_w(src_w), .src_h(src_h), .ofs_h(ofs_h), .ofs_v(ofs_v),
        .tgt_w(tgt_w), .tgt_h(tgt_h), .busy(busy), .done(done),
        .pre_ratio_h(pre_ratio_h), .pre_ratio_v(pre_ratio_v),
        .pre_shift_h(pre_shift_h), .pre_shift_v(pre_shift_v),
        .shift_factor(shift_factor), .pre_dst_w(pre_dst_w), .pre_dst_h(pre_dst_h),
        .main_ratio_h(main_ratio_h), .main_ratio_v(main_ratio_v),
        .scale_up_h(scale_up_h), .scale_up_v(scale_up_v), .err_size(err_size),
        .err_range(err_range), .err_mismatch(err_mismatch), .err_linebuf(err_linebuf));

    task automatic chk(string tag, int act, int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    // behavioural model of one run, filling p[]
    task automatic model(int pv, int sw, int sh, int ow, int ov, int tw, int th);
        int ew, eh, shh, shv;
        ew = sw - 2 * ow;
        eh = sh - 2 * ov;
        foreach (p[i]) p[i] = 0;
        if (ew <= 0 || eh <= 0 || tw == 0 || th == 0) begin
            p[13] = 1;
            return;
        end
        shh = 0; shv = 0;
        for (int k = 0; k < 6; k++) begin
            if (ew >= (tw << k)) shh = k;
            if (eh >= (th << k)) shv = k;
        end
        p[0]  = 1 << shh;             p[1]  = 1 << shv;
        p[2]  = shh;                  p[3]  = shv;
        p[4]  = 10 - shh - shv;
        p[5]  = ew / (1 << shh);      p[6]  = eh / (1 << shv);
        p[7]  = (ew * 256) / (tw << shh);
        p[8]  = (eh * 256) / (th << shv);
        p[9]  = (ew <= tw);           p[10] = (eh <= th);
        p[11] = 0; p[12] = 0;
        p[14] = (ew >= 64 * tw) || (eh >= 64 * th);
        p[15] = (p[9] != p[10]);
        p[16] = (pv != 0) && (p[5] > 640);
    endtask

    // per-clock comparison away from the active edge
    always @(negedge clk) begin
        if (mon_on) begin
            if (done) begin
                if (!pend) chk("R1 unexpected done", 1, 0);
                foreach (e[i]) e[i] = p[i];
                pend = 0;
                chk("R1 busy low with done", int'(busy), 0);
            end else if (pend) begin
                chk("R1 busy during run", int'(busy), 1);
            end else begin
                chk("R1 idle busy", int'(busy), 0);
            end
            chk("R3 pre_ratio_h", int'(pre_ratio_h), e[0]);
            chk("R3 pre_ratio_v", int'(pre_ratio_v), e[1]);
            chk("R3 R4 pre_shift_h", int'(pre_shift_h), e[2]);
            chk("R3 R4 pre_shift_v", int'(pre_shift_v), e[3]);
            chk("R5 shift_factor", int'(shift_factor), e[4]);
            chk("R6 pre_dst_w", int'(pre_dst_w), e[5]);
            chk("R6 pre_dst_h", int'(pre_dst_h), e[6]);
            chk("R7 main_ratio_h", int'(main_ratio_h), e[7]);
            chk("R7 main_ratio_v", int'(main_ratio_v), e[8]);
            chk("R8 scale_up_h", int'(scale_up_h), e[9]);
            chk("R8 scale_up_v", int'(scale_up_v), e[10]);
            chk("R2 err_size", int'(err_size), e[13]);
            chk("R4 err_range", int'(err_range), e[14]);
            chk("R8 err_mismatch", int'(err_mismatch), e[15]);
            chk("R9 err_linebuf", int'(err_linebuf), e[16]);
        end
    end

    task automatic launch(int pv, int sw, int sh, int ow, int ov, int tw, int th);
        @(negedge clk);
        preview = pv[0];
        src_w = 12'(sw); src_h = 12'(sh);
        ofs_h = 11'(ow); ofs_v = 11'(ov);
        tgt_w = 12'(tw); tgt_h = 12'(th);
        start = 1'b1;
        @(posedge clk);
        model(pv, sw, sh, ow, ov, tw, th);
        pend = 1;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic wait_done();
        int n = 0;
        while (pend && n < 200) begin
            @(negedge clk);
            n++;
        end
        if (pend) begin
            chk("R1 done timeout", 0, 1);
            pend = 0;
        end
        repeat (2) @(negedge clk);
    endtask

    task automatic run(int pv, int sw, int sh, int ow, int ov, int tw, int th);
        launch(pv, sw, sh, ow, ov, tw, th);
        wait_done();
    endtask

    initial begin
        foreach (e[i]) e[i] = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        mon_on = 1;
        @(negedge clk);
        // R10 reset state is covered by the monitor with e[] all zero
        chk("R10 reset done", int'(done), 0);

        run(0, 640, 480, 0, 0, 320, 240);      // R3 R6 R7 plain halving
        run(0, 1280, 1024, 16, 8, 100, 60);    // R2 R3 R7 crop and mixed ratios
        run(0, 100, 80, 0, 0, 200, 160);       // R8 both enlarge
        run(0, 200, 100, 0, 0, 100, 200);      // R8 mismatch
        run(0, 4000, 100, 0, 0, 50, 100);      // R4 out of range
        run(0, 3200, 320, 0, 0, 100, 10);      // R3 R4 exactly 32x: no error
        run(0, 640, 640, 0, 0, 10, 10);        // R4 exactly 64x: error
        run(0, 300, 300, 0, 0, 300, 300);      // R8 effective equals target
        run(0, 100, 100, 50, 0, 10, 10);       // R2 zero width after crop
        run(0, 100, 100, 0, 60, 10, 10);       // R2 negative height after crop
        run(0, 100, 100, 0, 0, 0, 10);         // R2 zero target
        run(1, 1400, 100, 0, 0, 1000, 100);    // R9 preview overflow
        run(0, 1400, 100, 0, 0, 1000, 100);    // R9 no check without preview
        run(1, 1280, 100, 0, 0, 640, 100);     // R9 exactly 640: no error
        run(1, 1282, 100, 0, 0, 641, 100);     // R9 641: error

        // R1 start during a run is ignored, inputs are captured once
        launch(0, 800, 600, 0, 0, 176, 144);
        repeat (3) @(negedge clk);
        src_w = 12'd100; tgt_w = 12'd7; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        wait_done();
        repeat (5) @(negedge clk);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired (R1) actual=hung expected=finished");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule